// File: doc/BRIEF.md
# Serial Port Bit-Rate Tick Generator

This block turns the system clock into the two timing strobes an asynchronous serial port needs. A sample strobe paces the receiver's oversampling. A bit strobe marks each bit period for the transmitter. Both are derived from a 12-bit divisor value D, so the sample strobe repeats every D+1 clock cycles.

The divisor is loaded through two byte-wide write strobes that share one data bus. The upper-part write places bits 3:0 of the bus into divisor bits 11:8. The lower-part write places all eight bits into divisor bits 7:0 and restarts the count at once. An upper-part write on its own never restarts anything: the countdown already under way finishes, and the new value is used from the next natural reload.

A fast-mode input halves the number of sample strobes per bit, from 16 to 8. A synchronous-mode input forces the normal ratio, so the fast-mode input has no effect while it is set. The resulting rate is fclk / (16·(D+1)) in normal mode and fclk / (8·(D+1)) in fast mode. For example, D = 51 gives the usual 9600 bit/s setting at normal speed.

Top module: `uart_baud_gen`

## Requirements
- R1: While reset is asserted, both strobes are low. After reset the divisor is 0, so `sample_tick` is high in every cycle from the first cycle after the first clock edge with reset released, and `bit_tick` is high in the 16th of those cycles.
- R2: With divisor D, `sample_tick` is high for exactly one cycle out of every D+1 cycles.
- R3: A cycle with `lo_wr` high loads `wr_data[7:0]` into divisor bits 7:0 and restarts both counters. If that write is sampled at clock edge E0, `sample_tick` is high in the cycles that follow edges E0+1+k·(D+1) for k ≥ 1, and low in every other cycle from edge E0+1 onward.
- R4: A cycle with `hi_wr` high loads `wr_data[3:0]` into divisor bits 11:8 without a restart. The countdown in progress completes with the old period, and the new divisor applies from the following reload.
- R5: During an upper-part write, `wr_data[7:4]` is ignored.
- R6: `bit_tick` is high only together with `sample_tick`, on every N-th sample strobe counted from a restart. N is 16 when `dbl_speed` is 0.
- R7: With `dbl_speed` = 1 and `sync_mode` = 0, N is 8.
- R8: With `sync_mode` = 1, N is 16 whatever the value of `dbl_speed`.
- R9: The full 12-bit range is honoured: D = 4095 gives a sample period of 4096 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hi_wr | input | 1 | Write strobe for divisor bits 11:8, taken from `wr_data[3:0]` |
| lo_wr | input | 1 | Write strobe for divisor bits 7:0; restarts the counters |
| wr_data | input | 8 | Write data for both strobes |
| dbl_speed | input | 1 | Selects 8 sample strobes per bit in asynchronous mode |
| sync_mode | input | 1 | Synchronous mode; forces 16 sample strobes per bit |
| sample_tick | output | 1 | One-cycle oversampling strobe |
| bit_tick | output | 1 | One-cycle bit-period strobe, coincident with a sample strobe |

## Verification
Take a lower-part write sampled at edge E0. The k-th sample strobe then falls in the cycle after edge E0+1+k·(D+1), and the m-th bit strobe in the cycle after edge E0+1+m·N·(D+1). Both include the one register stage of the restart and the one register stage of the strobe. An upper-part write sampled at edge Ew changes only the period that follows a reload at an edge later than Ew.

The bench drives inputs and samples outputs on falling edges. It counts falling edges from the write, starting one cycle after it. In every cycle of each window it compares both strobes against that arithmetic, checking that each strobe is absent as well as present.

// File: rtl/rate_gen_pkg.sv
`timescale 1ns/1ps
// Shared sizing for the bit-rate tick generator.
// Assumes the lower write part is one data byte wide.
package rate_gen_pkg;
    localparam int DIV_W      = 12;            // divisor width
    localparam int LO_W       = 8;             // width of the lower write part
    localparam int OVS_NORMAL = 16;            // sample strobes per bit, normal mode
    localparam int OVS_FAST   = 8;             // sample strobes per bit, fast mode
endpackage

// File: rtl/rg_divisor_reg.sv
`timescale 1ns/1ps
// Divisor register. It is built from two write parts that share one data bus.
// The upper-part write takes only the low DIV_W-LO_W bits of the bus.
// The lower-part write raises a one-cycle restart pulse that lines up with the new value.
// Assumes DIV_W > LO_W.
module rg_divisor_reg #(
    parameter int DIV_W = 12,
    parameter int LO_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hi_wr,
    input  logic             lo_wr,
    input  logic [LO_W-1:0]  wr_data,
    output logic [DIV_W-1:0] div_q,
    output logic             restart_q
);
    localparam int HI_W = DIV_W - LO_W;

    // Capture the divisor parts and flag a restart after each lower-part write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q     <= '0;
            restart_q <= 1'b0;
        end else begin
            restart_q <= lo_wr;
            if (hi_wr)
                div_q[DIV_W-1:LO_W] <= wr_data[HI_W-1:0];
            if (lo_wr)
                div_q[LO_W-1:0] <= wr_data;
        end
    end

    assert_hi_keeps_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_wr && !lo_wr) |=> (div_q[LO_W-1:0] == $past(div_q[LO_W-1:0])));

    assert_hi_reserved_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr |=> (div_q[DIV_W-1:LO_W] == $past(wr_data[HI_W-1:0])));
endmodule

// File: rtl/rg_prescale_cnt.sv
`timescale 1ns/1ps
// Prescaler down-counter. It reloads the divisor when it reaches zero and on restart.
// It emits a registered one-cycle strobe for each pass through zero, giving a period of div+1.
// Assumes that restart is a single-cycle pulse.
module rg_prescale_cnt #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // Count down, reload on zero or restart, and register the zero strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (restart) begin
            cnt  <= div;
            tick <= 1'b0;
        end else if (cnt == '0) begin
            cnt  <= div;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt - 1'b1;
            tick <= 1'b0;
        end
    end

    assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    assert_restart_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> ((cnt == $past(div)) && !tick));
endmodule

// File: rtl/rg_ovs_div.sv
`timescale 1ns/1ps
// Oversampling divider. It counts sample strobes and flags the last one of each bit period.
// The ratio is OVS_FAST in fast asynchronous mode and OVS_NORMAL otherwise.
// Assumes OVS_NORMAL >= OVS_FAST, both powers of two.
module rg_ovs_div #(
    parameter int OVS_NORMAL = 16,
    parameter int OVS_FAST   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic tick,
    input  logic dbl_speed,
    input  logic sync_mode,
    output logic bit_tick
);
    localparam int OVS_W = $clog2(OVS_NORMAL);

    logic [OVS_W-1:0] ocnt;
    logic [OVS_W-1:0] last_idx;
    logic             at_last;

    // Choose the final strobe index; synchronous mode overrides fast mode.
    always_comb begin
        last_idx = (dbl_speed && !sync_mode) ? OVS_W'(OVS_FAST - 1) : OVS_W'(OVS_NORMAL - 1);
        at_last  = (ocnt >= last_idx);
        bit_tick = tick && at_last;
    end

    // Advance on each sample strobe, wrap after the final one, clear on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            ocnt <= '0;
        else if (tick)
            ocnt <= at_last ? '0 : ocnt + 1'b1;
    end

    assert_restart_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (ocnt == '0));
endmodule

// File: rtl/uart_baud_gen.sv
`timescale 1ns/1ps
// Bit-rate tick generator for an asynchronous serial port.
// Chains the divisor register, the prescaler and the oversampling divider.
// Assumes the write strobes are synchronous to clk and that software keeps the upper bits
// of an upper-part write at zero (they are ignored here).
module uart_baud_gen
    import rate_gen_pkg::*;
#(
    parameter int DIV_W      = rate_gen_pkg::DIV_W,
    parameter int LO_W       = rate_gen_pkg::LO_W,
    parameter int OVS_NORMAL = rate_gen_pkg::OVS_NORMAL,
    parameter int OVS_FAST   = rate_gen_pkg::OVS_FAST
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hi_wr,
    input  logic            lo_wr,
    input  logic [LO_W-1:0] wr_data,
    input  logic            dbl_speed,
    input  logic            sync_mode,
    output logic            sample_tick,
    output logic            bit_tick
);
    logic [DIV_W-1:0] div_q;
    logic             restart_q;

    rg_divisor_reg #(.DIV_W(DIV_W), .LO_W(LO_W)) i_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .hi_wr     (hi_wr),
        .lo_wr     (lo_wr),
        .wr_data   (wr_data),
        .div_q     (div_q),
        .restart_q (restart_q)
    );

    rg_prescale_cnt #(.DIV_W(DIV_W)) i_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart_q),
        .div     (div_q),
        .tick    (sample_tick)
    );

    rg_ovs_div #(.OVS_NORMAL(OVS_NORMAL), .OVS_FAST(OVS_FAST)) i_ovs (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart_q),
        .tick      (sample_tick),
        .dbl_speed (dbl_speed),
        .sync_mode (sync_mode),
        .bit_tick  (bit_tick)
    );

    assert_bit_on_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> sample_tick);
endmodule

// File: tb/test_uart_baud_gen.sv
`timescale 1ns/1ps
// Self-checking bench: a per-cycle comparison of both strobes against arithmetic expectations.
module test_uart_baud_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hi_wr = 1'b0;
    logic       lo_wr = 1'b0;
    logic [7:0] wr_data = '0;
    logic       dbl_speed = 1'b0;
    logic       sync_mode = 1'b0;
    logic       sample_tick;
    logic       bit_tick;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    uart_baud_gen i_uart_baud_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .hi_wr       (hi_wr),
        .lo_wr       (lo_wr),
        .wr_data     (wr_data),
        .dbl_speed   (dbl_speed),
        .sync_mode   (sync_mode),
        .sample_tick (sample_tick),
        .bit_tick    (bit_tick)
    );

    // Compare one output bit and record the result.
    task automatic check_bit(string tag, string what, logic got, logic exp, int n);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: got %0b expected %0b", tag, what, n, got, exp);
        end
    endtask

    task automatic write_hi(logic [7:0] v);
        @(negedge clk);
        hi_wr = 1'b1; wr_data = v;
        @(negedge clk);
        hi_wr = 1'b0;
    endtask

    // Ends on the falling edge just after the write's sampling edge (cycle 0).
    task automatic write_lo(logic [7:0] v);
        @(negedge clk);
        lo_wr = 1'b1; wr_data = v;
        @(negedge clk);
        lo_wr = 1'b0;
    endtask

    // Check every cycle from 1 to len after a lower-part write.
    // Optionally issue an upper-part write in cycle hw that changes the divisor to d_new.
    task automatic run_window(string tag, int d_old, int ratio, int len,
                              int hw, logic [7:0] hdata, int d_new);
        int   next_s;
        int   scount;
        logic exp_s;
        logic exp_b;
        next_s = d_old + 2;
        scount = 0;
        for (int n = 0; n <= len; n++) begin
            if (n >= 1) begin
                exp_s = (n == next_s);
                exp_b = exp_s && (((scount + 1) % ratio) == 0);
                check_bit(tag, "sample_tick", sample_tick, exp_s, n);
                check_bit(tag, "bit_tick", bit_tick, exp_b, n);
                if (exp_s) begin
                    scount++;
                    next_s = n + (((hw >= 0) && (n > hw + 1)) ? d_new + 1 : d_old + 1);
                end
            end
            hi_wr = (n == hw);
            if (n == hw) wr_data = hdata;
            @(negedge clk);
        end
        hi_wr = 1'b0;
    endtask

    task automatic program_and_run(string tag, int d, int ratio);
        write_hi(8'(d >> 8));
        write_lo(8'(d & 255));
        run_window(tag, d, ratio, 2 * ratio * (d + 1) + 2, -1, 8'h00, d);
    endtask

    initial begin
        int dlist[5];
        dlist = '{0, 1, 2, 5, 51};
        // R1: outputs stay low while in reset
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check_bit("R1", "sample_tick in reset", sample_tick, 1'b0, i);
            check_bit("R1", "bit_tick in reset", bit_tick, 1'b0, i);
        end
        rst_n = 1'b1;
        // R1 R6: divisor 0 after reset, strobe every cycle, bit strobe on the 16th
        for (int n = 1; n <= 33; n++) begin
            @(negedge clk);
            check_bit("R1", "sample_tick after reset", sample_tick, 1'b1, n);
            check_bit("R1 R6", "bit_tick after reset", bit_tick, (n % 16) == 0, n);
        end
        // R2 R3 R6 R7 R8: sweep the divisors over the three mode settings
        for (int m = 0; m < 3; m++) begin
            @(negedge clk);
            dbl_speed = (m != 0);
            sync_mode = (m == 2);
            for (int k = 0; k < 5; k++) begin
                if (m == 0)      program_and_run("R2 R3 R6", dlist[k], 16);
                else if (m == 1) program_and_run("R7", dlist[k], 8);
                else             program_and_run("R8", dlist[k], 16);
            end
        end
        // R5: reserved bits set in the upper-part write; divisor 300 expected
        @(negedge clk);
        dbl_speed = 1'b0; sync_mode = 1'b0;
        write_hi(8'hA1);
        write_lo(8'h2C);
        run_window("R5", 300, 16, 2 * 16 * 301 + 2, -1, 8'h00, 300);
        // R4 R5: an upper-part write mid-count changes 259 to 3 at the next reload only
        write_hi(8'h01);
        write_lo(8'h03);
        run_window("R4 R5", 259, 16, 700, 261, 8'hF0, 3);
        // R9 R7: full-range divisor in fast mode
        @(negedge clk);
        dbl_speed = 1'b1;
        write_hi(8'h0F);
        write_lo(8'hFF);
        run_window("R9 R7", 4095, 8, 8 * 4096 + 2, -1, 8'h00, 4095);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete (R1 through all requirements unverified)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule